// File: doc/BRIEF.md
# Up-Counter with Lagging Terminal-Count Clear

This block is a synchronous up-counter whose return to zero is ordered by a value decoder, not by a hard modulus. The decoder watches for one chosen count (parameter `DETECT`, default 5) and issues an active-low clear request. That request passes through a delay line of `LATENCY` clock cycles (default 4) before it reaches the counter. The delay line models a decode path that is slower than the clock period.

While the request is in flight the counter keeps stepping, so it overshoots the detected value. It reaches `DETECT + LATENCY - 1` and then loads zero, which gives a modulus of `DETECT + LATENCY`. With the defaults it cycles through 0 to 8 (mod-9). With `LATENCY = 0` the clear acts at once: the detected value never shows up and the counter runs 0 to `DETECT - 1`.

The block fits where a designer has to predict, cycle by cycle, what a late terminal-count clear does to a counter's sequence. Elaboration rejects any parameter set whose highest reached value does not fit in the count width, and it rejects a `DETECT` of zero.

Top module: `tc_lag_counter`

## Requirements
- R1: While `rst_n` is low, `count` is 0 and `wrap` is 0. Asserting `rst_n` between clock edges clears `count` at once, without waiting for a clock edge.
- R2: On each rising edge with `en` high, `count` grows by exactly one, unless a delayed clear is due on that edge.
- R3: Reaching `DETECT` does not stop the counter. The values `DETECT` through `DETECT+LATENCY-1` (5, 6, 7, 8 by default) all appear as `count` values in turn.
- R4: The enabled edge taken while `count` equals `DETECT+LATENCY-1` loads 0. The counter never goes above that value, and the sequence repeats every `DETECT+LATENCY` enabled edges (9 by default).
- R5: `wrap` is 1 exactly during the cycles in which `en` is 1 and `count` equals `DETECT+LATENCY-1`, which are the cycles whose closing edge loads 0. At all other times it is 0.
- R6: With `en` low, `count` holds and a clear request already in flight holds its place. A pause while the clear is in flight therefore moves the wrap later in time but leaves the value sequence unchanged.
- R7: With `LATENCY = 0` (tested with `DETECT = 5`), the counter runs 0 to 4 and then 0 again. The value 5 never appears.
- R8: Reset also removes every clear request in flight. A reset taken while `count` is 6 (default parameters) is followed by a full 0 to 8 run, with no early wrap.
- R9: A parameter set whose top value is exactly 15 (tested with `DETECT = 10`, `LATENCY = 6`) counts 0 through 15 and then 0, over 16 enabled edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous reset, active low; clears the count and the delay line |
| en | input | 1 | Count enable; when low, the count and the delay line hold |
| count | output | WIDTH | Present count value |
| wrap | output | 1 | High in the cycle whose closing edge returns the count to zero |

## Verification
A steady run of enabled edges covers the overshoot from 5 to 8 and the mod-9 return, and it separates a correctly timed clear from one that arrives a cycle early or late. An enable pattern that drops one cycle in three, plus a deliberate pause while the clear is in flight, separates a delay line that holds from one that keeps shifting while the counter is paused. A reset taken mid-flight shows whether stale requests are flushed. Two extra builds cover the zero-latency case, where 5 must never appear, and the case whose top value is 15, which is the edge of the 4-bit range.

// File: rtl/tc_lag_pkg.sv
package tc_lag_pkg;

  typedef enum logic [1:0] {
    ACT_HOLD  = 2'b00,
    ACT_STEP  = 2'b01,
    ACT_CLEAR = 2'b10
  } ctr_act_e;

  // Highest value the counter reaches before returning to zero.
  function automatic int unsigned top_value(input int unsigned detect,
                                            input int unsigned latency);
    return detect + latency - 1;
  endfunction

  // Number of enabled edges in one full sequence.
  function automatic int unsigned cycle_len(input int unsigned detect,
                                            input int unsigned latency);
    return detect + latency;
  endfunction

  // Legal when the top value fits the width and detect is nonzero.
  function automatic bit params_legal(input int unsigned width,
                                      input int unsigned detect,
                                      input int unsigned latency);
    longint unsigned lim;
    lim = (longint'(1) << width) - 1;
    return (detect >= 1) && (longint'(detect) + longint'(latency) - 1 <= lim);
  endfunction

endpackage

// File: rtl/tc_lag_decode.sv
module tc_lag_decode #(
  parameter int unsigned WIDTH  = 4,
  parameter int unsigned DETECT = 5
) (
  input  logic [WIDTH-1:0] next_val,
  output logic             hit_n
);
  localparam logic [WIDTH-1:0] DET_V = WIDTH'(DETECT);

  logic [WIDTH-1:0] bit_eq;

  // Bitwise agreement, then an AND-reduction with inverted output.
  genvar b;
  generate
    for (b = 0; b < WIDTH; b++) begin : g_bit
      assign bit_eq[b] = ~(next_val[b] ^ DET_V[b]);
    end
  endgenerate

  assign hit_n = ~(&bit_eq);

endmodule

// File: rtl/tc_lag_line.sv
module tc_lag_line #(
  parameter int unsigned DEPTH = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic din_n,
  output logic dout_n
);

  generate
    if (DEPTH == 0) begin : g_wire
      assign dout_n = din_n;
    end else begin : g_pipe
      logic [DEPTH-1:0] stg_n;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          stg_n <= '1;
        end else if (en) begin
          stg_n[0] <= din_n;
          for (int k = 1; k < DEPTH; k++) begin
            stg_n[k] <= stg_n[k-1];
          end
        end
      end

      assign dout_n = stg_n[DEPTH-1];

      // At most one clear request is in flight at a time.
      AST_ONE_IN_FLIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~stg_n)); // R3

      // A paused line keeps its contents.
      AST_LINE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(stg_n)); // R6
    end
  endgenerate

endmodule

// File: rtl/tc_lag_core.sv
module tc_lag_core #(
  parameter int unsigned WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             clr_n,
  output logic [WIDTH-1:0] cnt,
  output logic [WIDTH-1:0] cnt_inc,
  output logic             clear_evt
);
  import tc_lag_pkg::*;

  ctr_act_e act;

  assign cnt_inc = cnt + WIDTH'(1);

  // The clear wins over the increment.
  always_comb begin
    if (!en)          act = ACT_HOLD;
    else if (!clr_n)  act = ACT_CLEAR;
    else              act = ACT_STEP;
  end

  assign clear_evt = (act == ACT_CLEAR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else begin
      unique case (act)
        ACT_CLEAR: cnt <= '0;
        ACT_STEP:  cnt <= cnt_inc;
        default:   cnt <= cnt;
      endcase
    end
  end

  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (en && clr_n) |=> (cnt == $past(cnt) + WIDTH'(1))); // R2

  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !clr_n) |=> (cnt == '0)); // R4

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(cnt)); // R6

endmodule

// File: rtl/tc_lag_counter.sv
module tc_lag_counter #(
  parameter int unsigned WIDTH   = 4,
  parameter int unsigned DETECT  = 5,
  parameter int unsigned LATENCY = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  output logic [WIDTH-1:0] count,
  output logic             wrap
);
  import tc_lag_pkg::*;

  localparam int unsigned      TOP   = top_value(DETECT, LATENCY);
  localparam logic [WIDTH-1:0] TOP_V = WIDTH'(TOP);
  localparam logic [WIDTH-1:0] DET_V = WIDTH'(DETECT);

  generate
    if (!params_legal(WIDTH, DETECT, LATENCY)) begin : g_bad_params
      $error("tc_lag_counter: DETECT+LATENCY-1 exceeds count range or DETECT is 0");
    end
  endgenerate

  logic [WIDTH-1:0] cnt_inc;
  logic             req_n;
  logic             late_clr_n;
  logic             clear_evt;

  // The decoder watches the value about to be entered, so LATENCY
  // counts the cycles spent in DETECT..TOP before the clear lands.
  tc_lag_decode #(
    .WIDTH  (WIDTH),
    .DETECT (DETECT)
  ) u_decode (
    .next_val (cnt_inc),
    .hit_n    (req_n)
  );

  tc_lag_line #(
    .DEPTH (LATENCY)
  ) u_line (
    .clk    (clk),
    .rst_n  (rst_n),
    .en     (en),
    .din_n  (req_n),
    .dout_n (late_clr_n)
  );

  tc_lag_core #(
    .WIDTH (WIDTH)
  ) u_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (en),
    .clr_n     (late_clr_n),
    .cnt       (count),
    .cnt_inc   (cnt_inc),
    .clear_evt (clear_evt)
  );

  assign wrap = clear_evt;

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    count <= TOP_V); // R4

  AST_WRAP_AT_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |-> (count == TOP_V)); // R5

  AST_TOP_WRAPS: assert property (@(posedge clk) disable iff (!rst_n)
    (en && count == TOP_V) |-> wrap); // R5

  generate
    if (LATENCY == 0) begin : g_no_lag_chk
      AST_DETECT_SKIPPED: assert property (@(posedge clk) disable iff (!rst_n)
        count != DET_V); // R7
    end
  endgenerate

endmodule

// File: tb/sim_tc_lag_counter.sv
module sim_tc_lag_counter;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0;

  logic [3:0] c0, c1, c2;
  logic       w0, w1, w2;

  always #5 clk = ~clk;

  tc_lag_counter #(.WIDTH(4), .DETECT(5), .LATENCY(4)) u0 (
    .clk(clk), .rst_n(rst_n), .en(en), .count(c0), .wrap(w0));
  tc_lag_counter #(.WIDTH(4), .DETECT(5), .LATENCY(0)) u1 (
    .clk(clk), .rst_n(rst_n), .en(en), .count(c1), .wrap(w1));
  tc_lag_counter #(.WIDTH(4), .DETECT(10), .LATENCY(6)) u2 (
    .clk(clk), .rst_n(rst_n), .en(en), .count(c2), .wrap(w2));

  localparam int TOP0 = 8;
  localparam int TOP1 = 4;
  localparam int TOP2 = 15;

  typedef struct {
    int    e0, e1, e2;
    string t0;
  } exp_t;

  exp_t  sbq[$];
  int    checks = 0;
  int    errors = 0;
  int    r0 = 0, r1 = 0, r2 = 0;
  string tag_override = "";
  bit    seen5_u0 = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  // Driver: applies one cycle of enable, checks wrap, queues next counts.
  task automatic step(input logic e);
    exp_t it;
    @(negedge clk);
    en = e;
    #1;
    chk(w0 == (e && r0 == TOP0), "R5", "u0 wrap", int'(w0), int'(e && r0 == TOP0));
    chk(w1 == (e && r1 == TOP1), "R7", "u1 wrap", int'(w1), int'(e && r1 == TOP1));
    chk(w2 == (e && r2 == TOP2), "R9", "u2 wrap", int'(w2), int'(e && r2 == TOP2));
    if (tag_override != "")  it.t0 = tag_override;
    else if (!e)             it.t0 = "R6";
    else if (r0 == TOP0)     it.t0 = "R4";
    else if (r0 >= 4)        it.t0 = "R3";
    else                     it.t0 = "R2";
    if (e) begin
      r0 = (r0 == TOP0) ? 0 : r0 + 1;
      r1 = (r1 == TOP1) ? 0 : r1 + 1;
      r2 = (r2 == TOP2) ? 0 : r2 + 1;
    end
    it.e0 = r0; it.e1 = r1; it.e2 = r2;
    sbq.push_back(it);
  endtask

  // Monitor: samples two time units after each rising edge.
  initial begin
    forever begin
      exp_t got;
      @(posedge clk);
      #2;
      if (sbq.size() > 0) begin
        got = sbq.pop_front();
        chk(int'(c0) == got.e0, got.t0, "u0 count", int'(c0), got.e0);
        chk(int'(c1) == got.e1, "R7", "u1 count", int'(c1), got.e1);
        chk(int'(c2) == got.e2, "R9", "u2 count", int'(c2), got.e2);
        if (c0 == 4'd5) seen5_u0 = 1;
      end
    end
  end

  task automatic mid_reset();
    @(negedge clk);
    en = 1'b0;
    #2;
    rst_n = 1'b0;
    #1;
    chk(c0 == 0 && c1 == 0 && c2 == 0, "R1", "async clear u0", int'(c0), 0);
    chk(w0 == 0, "R1", "wrap in reset", int'(w0), 0);
    r0 = 0; r1 = 0; r2 = 0;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(c0 == 0 && c1 == 0 && c2 == 0, "R1", "reset count", int'(c0), 0);
    chk(w0 == 0 && w1 == 0 && w2 == 0, "R1", "reset wrap", int'(w0), 0);
    rst_n = 1'b1;

    // Steady enable: two full u0 periods, several u1 periods.
    for (int i = 0; i < 20; i++) step(1'b1);
    chk(seen5_u0, "R3", "u0 passed through 5", int'(seen5_u0), 1);

    // Sparse enable: one cycle in three dropped.
    for (int i = 0; i < 36; i++) step((i % 3) != 2);

    // Pause while the clear is in flight.
    for (int i = 0; i < 20 && r0 != 6; i++) step(1'b1);
    tag_override = "R6";
    for (int i = 0; i < 4; i++) step(1'b0);
    for (int i = 0; i < 6; i++) step(1'b1);
    tag_override = "";

    // Reset while a clear is in flight, then a full clean run.
    for (int i = 0; i < 20 && r0 != 6; i++) step(1'b1);
    mid_reset();
    tag_override = "R8";
    for (int i = 0; i < 12; i++) step(1'b1);
    tag_override = "";

    // Enough edges for u2 to pass 15 and wrap.
    for (int i = 0; i < 34; i++) step(1'b1);
    step(1'b0);

    @(negedge clk);
    @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule